// File: doc/BRIEF.md
# Instruction Energy Meter

This block turns a stream of retired-instruction events into an energy estimate. Every event names one of four instruction classes. The block charges the event two amounts. The first is a base cost that belongs to the class. The second is a transition cost that depends on the unordered pair made of the previous class and the current class. The block adds both amounts to a running energy total. It also counts the instructions in the current window.

Software reads the energy total and the instruction count. It divides the energy by the product of the count and the clock period to get average power; that division is not part of this block. A simple register write port reprograms the base-cost table and the transition-cost table. A clear input starts a new measurement window.

Top module: `insn_energy_meter`

## Requirements
- R1: After a synchronous active-high reset, `energy_o` and `count_o` are 0, and both cost tables hold their default contents.
- R2: An event with `ev_valid_i` high adds base[class] + trans{previous, class} to `energy_o` and adds 1 to `count_o`. Both results are visible in the cycle after the clock edge that samples the event.
- R3: At the start of every window the previous class is taken to be ADD. A window starts at reset and at every clear.
- R4: The class encoding on `ev_class_i` is LOAD=0, DLOAD=1, ADD=2, MULT=3. The default base costs, in units of 0.01 pJ, are LOAD 198, DLOAD 237, ADD 99 and MULT 0.
- R5: The default transition costs, in units of 0.01 pJ, are ADD/DLOAD 119, DLOAD/LOAD 15 and LOAD/ADD 119. Every other pair, same-class pairs included, defaults to 0. Starting from ADD, the sequence DLOAD, LOAD, ADD accumulates 356, then 569, then 787.
- R6: The transition table is symmetric. A write to the pair (a,b) also sets the pair (b,a).
- R7: A port write with `cfg_we_i` high programs an entry. With `cfg_pair_i`=0 it sets base[`cfg_a_i`]. With `cfg_pair_i`=1 it sets trans{`cfg_a_i`,`cfg_b_i`}. An event in the same cycle as the write still uses the old value.
- R8: The energy total saturates at 2^32-1 and does not wrap.
- R9: A clear with no event sets both totals to 0. A clear in the same cycle as an event starts the window with that event: the count becomes 1 and the energy becomes base + trans{ADD, class}.
- R10: With no event and no clear, `energy_o` and `count_o` hold their values, even when a table write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear_i | input | 1 | Start a new measurement window |
| ev_valid_i | input | 1 | A retired-instruction event is present |
| ev_class_i | input | 2 | Instruction class of the event |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_pair_i | input | 1 | 0 selects the base table, 1 selects the transition table |
| cfg_a_i | input | 2 | Class index, or the first class of a pair |
| cfg_b_i | input | 2 | Second class of a pair |
| cfg_data_i | input | 16 | Cost value to write |
| energy_o | output | 32 | Accumulated energy, in units of 0.01 pJ, saturating |
| count_o | output | 32 | Instruction count of the current window |

## Verification
Saturation is the hardest case to reach from the ports, because the default costs would need millions of events to get there. The stimulus first programs the MULT base cost and the MULT/MULT transition cost to their 16-bit maximum. It then holds a MULT event valid for tens of thousands of consecutive cycles, until the 32-bit total reaches its ceiling. Further events are then checked to leave the total pinned at the ceiling. The other hard case is a clear that lands in the same cycle as an event; the stimulus drives both in one cycle on purpose.

// File: rtl/ienergy_pkg.sv
package ienergy_pkg;
  localparam int unsigned CLS_LOAD  = 0;
  localparam int unsigned CLS_DLOAD = 1;
  localparam int unsigned CLS_ADD   = 2;
  localparam int unsigned CLS_MULT  = 3;

  // Default base cost of a class, in units of 0.01 pJ.
  function automatic int unsigned dflt_base(input int unsigned c);
    case (c)
      CLS_LOAD:  return 198;
      CLS_DLOAD: return 237;
      CLS_ADD:   return 99;
      default:   return 0;
    endcase
  endfunction

  // Default transition cost of an unordered class pair, in units of 0.01 pJ.
  function automatic int unsigned dflt_trans(input int unsigned a, input int unsigned b);
    int unsigned lo;
    int unsigned hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (lo == CLS_LOAD  && hi == CLS_DLOAD) return 15;
    if (lo == CLS_LOAD  && hi == CLS_ADD)   return 119;
    if (lo == CLS_DLOAD && hi == CLS_ADD)   return 119;
    return 0;
  endfunction
endpackage

// File: rtl/ienergy_cost_tables.sv
module ienergy_cost_tables #(
  parameter int COST_W = 16,
  parameter int NCLS   = 4,
  localparam int IW    = $clog2(NCLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_pair,
  input  logic [IW-1:0]     wr_a,
  input  logic [IW-1:0]     wr_b,
  input  logic [COST_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_cur,
  input  logic [IW-1:0]     rd_prev,
  output logic [COST_W-1:0] base_o,
  output logic [COST_W-1:0] trans_o
);
  import ienergy_pkg::*;

  logic [COST_W-1:0] base_q  [NCLS];
  logic [COST_W-1:0] trans_q [NCLS][NCLS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCLS; i++) begin
        base_q[i] <= COST_W'(dflt_base(i));
        for (int j = 0; j < NCLS; j++)
          trans_q[i][j] <= COST_W'(dflt_trans(i, j));
      end
    end else if (wr_en) begin
      if (wr_pair) begin
        trans_q[wr_a][wr_b] <= wr_data;
        trans_q[wr_b][wr_a] <= wr_data;
      end else begin
        base_q[wr_a] <= wr_data;
      end
    end
  end

  assign base_o  = base_q[rd_cur];
  assign trans_o = trans_q[rd_prev][rd_cur];

  for (genvar gi = 0; gi < NCLS; gi++) begin : g_row
    for (genvar gj = 0; gj < NCLS; gj++) begin : g_col
      // R6
      trans_sym_chk: assert property (@(posedge clk) disable iff (rst)
        trans_q[gi][gj] == trans_q[gj][gi]);
    end
  end
endmodule

// File: rtl/ienergy_accum.sv
module ienergy_accum #(
  parameter int COST_W    = 16,
  parameter int ACC_W     = 32,
  parameter int CNT_W     = 32,
  parameter int NCLS      = 4,
  parameter int START_CLS = 2,
  localparam int IW       = $clog2(NCLS),
  localparam int SUM_W    = ACC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              ev_valid,
  input  logic [IW-1:0]     ev_cls,
  input  logic [COST_W-1:0] base_cost,
  input  logic [COST_W-1:0] trans_cost,
  output logic [ACC_W-1:0]  acc_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [IW-1:0]     prev_o
);
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IW-1:0]    prev_q;
  logic [ACC_W-1:0] acc_start;
  logic [CNT_W-1:0] cnt_start;
  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] acc_next;

  always_comb begin
    acc_start = clear ? '0 : acc_q;
    cnt_start = clear ? '0 : cnt_q;
    sum       = {1'b0, acc_start} + SUM_W'(base_cost) + SUM_W'(trans_cost);
    acc_next  = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      prev_q <= IW'(START_CLS);
    end else if (ev_valid) begin
      acc_q  <= acc_next;
      cnt_q  <= cnt_start + CNT_W'(1);
      prev_q <= ev_cls;
    end else if (clear) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      prev_q <= IW'(START_CLS);
    end
  end

  assign acc_o  = acc_q;
  assign cnt_o  = cnt_q;
  assign prev_o = prev_q;

  // R8
  acc_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> acc_q >= $past(acc_q));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !clear) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev_valid && !clear) |=> ($stable(acc_q) && $stable(cnt_q)));
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !ev_valid) |=> (acc_q == '0 && cnt_q == '0 && prev_q == IW'(START_CLS)));
  // R9
  clear_first_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && ev_valid) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/insn_energy_meter.sv
module insn_energy_meter #(
  parameter int COST_W = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 32,
  parameter int NCLS   = 4,
  localparam int IW    = $clog2(NCLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              ev_valid_i,
  input  logic [IW-1:0]     ev_class_i,
  input  logic              cfg_we_i,
  input  logic              cfg_pair_i,
  input  logic [IW-1:0]     cfg_a_i,
  input  logic [IW-1:0]     cfg_b_i,
  input  logic [COST_W-1:0] cfg_data_i,
  output logic [ACC_W-1:0]  energy_o,
  output logic [CNT_W-1:0]  count_o
);
  import ienergy_pkg::*;

  logic [IW-1:0]     prev_cls;
  logic [IW-1:0]     lookup_prev;
  logic [COST_W-1:0] base_cost;
  logic [COST_W-1:0] trans_cost;

  // A window start forces the previous class to ADD for the lookup.
  assign lookup_prev = clear_i ? IW'(CLS_ADD) : prev_cls;

  ienergy_cost_tables #(.COST_W(COST_W), .NCLS(NCLS)) tables_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we_i),
    .wr_pair (cfg_pair_i),
    .wr_a    (cfg_a_i),
    .wr_b    (cfg_b_i),
    .wr_data (cfg_data_i),
    .rd_cur  (ev_class_i),
    .rd_prev (lookup_prev),
    .base_o  (base_cost),
    .trans_o (trans_cost)
  );

  ienergy_accum #(
    .COST_W(COST_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
    .NCLS(NCLS), .START_CLS(CLS_ADD)
  ) accum_i (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear_i),
    .ev_valid   (ev_valid_i),
    .ev_cls     (ev_class_i),
    .base_cost  (base_cost),
    .trans_cost (trans_cost),
    .acc_o      (energy_o),
    .cnt_o      (count_o),
    .prev_o     (prev_cls)
  );

  // R3
  start_prev_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clear_i && !ev_valid_i) |-> prev_cls == IW'(CLS_ADD));
endmodule

// File: tb/insn_energy_meter_tb_top.sv
module insn_energy_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOAD = 0, DLOAD = 1, ADD = 2, MULT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear_i = 1'b0;
  logic        ev_valid_i = 1'b0;
  logic [1:0]  ev_class_i = '0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_pair_i = 1'b0;
  logic [1:0]  cfg_a_i = '0;
  logic [1:0]  cfg_b_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic [31:0] energy_o;
  logic [31:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_energy_meter dut_i (
    .clk(clk), .rst(rst), .clear_i(clear_i),
    .ev_valid_i(ev_valid_i), .ev_class_i(ev_class_i),
    .cfg_we_i(cfg_we_i), .cfg_pair_i(cfg_pair_i),
    .cfg_a_i(cfg_a_i), .cfg_b_i(cfg_b_i), .cfg_data_i(cfg_data_i),
    .energy_o(energy_o), .count_o(count_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clear_i = 1'b0; ev_valid_i = 1'b0; cfg_we_i = 1'b0;
  endtask

  task automatic send(input int c);
    ev_valid_i = 1'b1; ev_class_i = 2'(c);
    tick();
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    tick();
  endtask

  task automatic cfg_write(input bit pair, input int a, input int b, input int d);
    cfg_we_i = 1'b1; cfg_pair_i = pair; cfg_a_i = 2'(a); cfg_b_i = 2'(b);
    cfg_data_i = 16'(d);
    tick();
  endtask

  task automatic t_reset();
    chk("R1", "energy after reset", energy_o, 0);
    chk("R1", "count after reset", count_o, 0);
  endtask

  task automatic t_default_seq();
    send(DLOAD);
    chk("R3", "DLOAD after ADD start", energy_o, 356);
    chk("R2", "count 1", count_o, 1);
    send(LOAD);
    chk("R5", "after LOAD", energy_o, 569);
    send(ADD);
    chk("R5", "after ADD", energy_o, 787);
    chk("R2", "count 3", count_o, 3);
  endtask

  task automatic t_mult_defaults();
    do_clear();
    send(MULT);
    chk("R4", "MULT default zero", energy_o, 0);
    send(LOAD);
    chk("R5", "unlisted pair MULT/LOAD zero", energy_o, 198);
    send(LOAD);
    chk("R5", "same class pair zero", energy_o, 396);
  endtask

  task automatic t_symmetric();
    cfg_write(1'b1, LOAD, MULT, 50);
    do_clear();
    send(MULT);
    send(LOAD);
    chk("R6", "mirrored pair MULT->LOAD", energy_o, 248);
    send(MULT);
    chk("R6", "direct pair LOAD->MULT", energy_o, 298);
  endtask

  task automatic t_base_write();
    do_clear();
    cfg_we_i = 1'b1; cfg_pair_i = 1'b0; cfg_a_i = 2'(ADD); cfg_data_i = 16'd500;
    send(ADD);
    chk("R7", "event during write uses old base", energy_o, 99);
    send(ADD);
    chk("R7", "new base applied", energy_o, 599);
    cfg_write(1'b0, ADD, 0, 99);
  endtask

  task automatic t_clear();
    send(LOAD);
    clear_i = 1'b1;
    send(DLOAD);
    chk("R9", "clear+event energy", energy_o, 356);
    chk("R9", "clear+event count", count_o, 1);
    do_clear();
    chk("R9", "clear energy", energy_o, 0);
    chk("R9", "clear count", count_o, 0);
    send(LOAD);
    chk("R3", "LOAD after clear uses ADD", energy_o, 317);
  endtask

  task automatic t_idle();
    tick(); tick();
    cfg_write(1'b1, ADD, LOAD, 7);
    chk("R10", "energy held", energy_o, 317);
    chk("R10", "count held", count_o, 1);
    cfg_write(1'b1, ADD, LOAD, 119);
  endtask

  task automatic t_saturation();
    longint unsigned model;
    longint unsigned maxv;
    maxv = 64'hFFFF_FFFF;
    cfg_write(1'b0, MULT, 0, 65535);
    cfg_write(1'b1, MULT, MULT, 65535);
    do_clear();
    send(MULT);
    model = 65535;
    chk("R8", "first MULT", energy_o, 32'(model));
    ev_valid_i = 1'b1; ev_class_i = 2'(MULT);
    for (int k = 0; k < 32769; k++) begin
      @(posedge clk);
      model = model + 131070;
      if (model > maxv) model = maxv;
    end
    #1;
    ev_valid_i = 1'b0;
    chk("R8", "saturated energy", energy_o, 32'(model));
    chk("R8", "saturated value max", energy_o, 32'hFFFF_FFFF);
    chk("R2", "count during saturation", count_o, 32770);
    send(MULT);
    chk("R8", "stays at max", energy_o, 32'hFFFF_FFFF);
    chk("R2", "count still counts", count_o, 32771);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_default_seq();
    t_mult_defaults();
    t_symmetric();
    t_base_write();
    t_clear();
    t_idle();
    t_saturation();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-scope run: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule